// File: doc/BRIEF.md
# RF Power and Arc Fast-Trip Interlock

This block removes the RF drive quickly when something goes wrong around an RF station. It watches a set of RF power level channels, a bank of arc detector inputs, some computed interlock inputs, some software interlock inputs and one vacuum-OK hardware input. Any fault sets a latched trip. The trip is driven on two independent output lines, so the drive is cut if either line asserts. A first-fault code records which source tripped first.

Each RF channel has its own level threshold and its own time limit. A channel faults only when its level stays strictly above the threshold for more consecutive cycles than its time limit, and only while the RF gate is high. Every source can be masked through a small write port, except the vacuum-OK input. When vacuum-OK drops, the block trips no matter how the masks are set or what the gate is doing. The latched trip is released by an explicit clear pulse. The clear has no effect while any unmasked source is still active.

Top module: `rf_trip_interlock`

## Requirements
- R1: After `rst` both trip lines are low and `first_src` is 0. All enable masks reset to 0 (disabled). Every threshold resets to all-ones and every time limit resets to 0.
- R2: Let channel c have enable bit c set and time limit T. While `rf_gate` is high, if its level is strictly greater than its threshold for T+1 consecutive cycles, the trip asserts at the clock edge that ends the (T+1)th cycle. If the level is high for T cycles or fewer, the channel does not trip.
- R3: A channel's over-threshold count restarts whenever its level is equal to or below its threshold, or `rf_gate` is low, for even a single cycle.
- R4: RF channels never trip while `rf_gate` is low, whatever their levels.
- R5: Arc, computed and software inputs are active high. An input trips the block one clock after it asserts if its enable bit is 1. It has no effect if its enable bit is 0.
- R6: When `vac_ok` is low at a clock edge, the trip asserts at that edge. This holds regardless of every mask and of `rf_gate`.
- R7: The trip stays asserted after the faulting source goes away, until `trip_clr` is sampled high.
- R8: `trip_clr` has no effect while any enabled source (or a low `vac_ok`) is active. Sources that are disabled do not block the clear.
- R9: `first_src` gives the code of the first fault and holds it until the trip is cleared:
  - 0 is vacuum.
  - 1..8 are RF channels 0..7.
  - 9..22 are arc inputs 0..13.
  - 23..24 are computed inputs 0..1.
  - 25..26 are software inputs 0..1.
  - When several sources fault on the same clock, the lowest code wins.
  - Later faults while tripped do not change the code.
- R10: `trip_a` and `trip_b` always assert and release on the same clock.
- R11: A write on `cfg_we` updates one register, chosen by `cfg_addr`:
  - Addresses 0..7 hold the thresholds of channels 0..7, taken from wdata[11:0].
  - Addresses 8..15 hold the time limits, taken from wdata[9:0].
  - Address 16 holds the RF enable mask, taken from wdata[7:0].
  - Address 17 holds the arc enable mask, taken from wdata[13:0].
  - Address 18 holds the computed enables in wdata[1:0] and the software enables in wdata[3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 16 | Configuration write data |
| rf_gate | input | 1 | RF gate; RF channels are evaluated only while high |
| rf_level | input | 96 | Eight 12-bit RF levels, channel c in bits [12c+11:12c] |
| arc_in | input | 14 | Arc detector inputs, active high |
| cmp_in | input | 2 | Computed interlock inputs, active high |
| sw_in | input | 2 | Software interlock inputs, active high |
| vac_ok | input | 1 | Vacuum good; low forces a trip, cannot be masked |
| trip_clr | input | 1 | Clear request for the latched trip |
| trip_a | output | 1 | Trip line A |
| trip_b | output | 1 | Trip line B (redundant copy) |
| first_src | output | 5 | Code of the first fault source |

## Verification
The hardest conditions to reach are time-limit boundaries on every channel and faults that coincide on one clock. The bench sweeps each channel over several time limits, holding the level high for every duration from zero to two cycles past the limit. It also builds runs that are broken by a single at-threshold cycle or a single gate-low cycle, to show the count restarts. Coinciding faults are produced by driving two sources on the same falling edge, so the priority of the first-fault code is visible at the ports. Clears are attempted while sources are still held, which shows that a clear is refused while a fault is active.

// File: rtl/itl_pkg.sv
package itl_pkg;

    localparam int RF_CH  = 8;
    localparam int ARC_CH = 14;
    localparam int CMP_CH = 2;
    localparam int SW_CH  = 2;
    localparam int LVL_W  = 12;
    localparam int TLIM_W = 10;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;

    localparam int NSRC  = 1 + RF_CH + ARC_CH + CMP_CH + SW_CH;
    localparam int SRC_W = $clog2(NSRC);

    // source code bases (priority: lower code wins)
    localparam int S_VAC = 0;
    localparam int S_RF  = 1;
    localparam int S_ARC = S_RF + RF_CH;
    localparam int S_CMP = S_ARC + ARC_CH;
    localparam int S_SW  = S_CMP + CMP_CH;

    // write-port address map
    localparam int A_THR    = 0;
    localparam int A_TLIM   = RF_CH;
    localparam int A_RF_EN  = 2 * RF_CH;
    localparam int A_ARC_EN = A_RF_EN + 1;
    localparam int A_AUX_EN = A_RF_EN + 2;

    typedef struct packed {
        logic [RF_CH-1:0]  rf_en;
        logic [ARC_CH-1:0] arc_en;
        logic [CMP_CH-1:0] cmp_en;
        logic [SW_CH-1:0]  sw_en;
    } mask_t;

    // lowest set index of a fault vector
    function automatic logic [SRC_W-1:0] lowest_set(input logic [NSRC-1:0] v);
        logic [SRC_W-1:0] r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) r = SRC_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/itl_cfg_regs.sv
module itl_cfg_regs
    import itl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    output logic [RF_CH*LVL_W-1:0]  thr_flat,
    output logic [RF_CH*TLIM_W-1:0] tlim_flat,
    output mask_t                   mask
);

    logic [LVL_W-1:0]  thr_q  [RF_CH];
    logic [TLIM_W-1:0] tlim_q [RF_CH];
    mask_t             mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RF_CH; i++) begin
                thr_q[i]  <= '1;
                tlim_q[i] <= '0;
            end
            mask_q <= '0;
        end else if (we) begin
            for (int i = 0; i < RF_CH; i++) begin
                if (int'(addr) == A_THR + i)  thr_q[i]  <= wdata[LVL_W-1:0];
                if (int'(addr) == A_TLIM + i) tlim_q[i] <= wdata[TLIM_W-1:0];
            end
            if (int'(addr) == A_RF_EN)  mask_q.rf_en  <= wdata[RF_CH-1:0];
            if (int'(addr) == A_ARC_EN) mask_q.arc_en <= wdata[ARC_CH-1:0];
            if (int'(addr) == A_AUX_EN) begin
                mask_q.cmp_en <= wdata[CMP_CH-1:0];
                mask_q.sw_en  <= wdata[CMP_CH+SW_CH-1:CMP_CH];
            end
        end
    end

    for (genvar g = 0; g < RF_CH; g++) begin : g_flat
        assign thr_flat[g*LVL_W +: LVL_W]    = thr_q[g];
        assign tlim_flat[g*TLIM_W +: TLIM_W] = tlim_q[g];
    end
    assign mask = mask_q;

endmodule

// File: rtl/itl_rf_timer.sv
module itl_rf_timer
    import itl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              gate,
    input  logic [LVL_W-1:0]  level,
    input  logic [LVL_W-1:0]  thr,
    input  logic [TLIM_W-1:0] tlim,
    output logic              fault
);

    logic              run;
    logic [TLIM_W-1:0] cnt_q;

    assign run = gate && (level > thr);

    // cnt_q = number of consecutive counted cycles before this one (saturating)
    always_ff @(posedge clk) begin
        if (rst || !run) cnt_q <= '0;
        else if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
    end

    assign fault = run && (cnt_q >= tlim);

    // R4: no channel fault outside the RF gate
    a_r4_gate_only: assert property (@(posedge clk) disable iff (rst)
        !gate |-> !fault);

    // R3: a nonzero count implies the previous cycle was counted
    a_r3_count_restart: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |-> $past(gate && (level > thr)));

    // R2: a fault with a nonzero limit needs an earlier counted cycle
    a_r2_not_early: assert property (@(posedge clk) disable iff (rst)
        (fault && tlim != '0) |-> (cnt_q != '0));

endmodule

// File: rtl/itl_trip_latch.sv
module itl_trip_latch
    import itl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [NSRC-1:0]  src,
    output logic             trip_a,
    output logic             trip_b,
    output logic [SRC_W-1:0] first
);

    logic             any_src;
    logic             trip_a_q, trip_b_q;
    logic [SRC_W-1:0] first_q;

    assign any_src = |src;

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_a_q <= 1'b0;
            first_q  <= '0;
        end else if (!trip_a_q) begin
            if (any_src) begin
                trip_a_q <= 1'b1;
                first_q  <= lowest_set(src);
            end
        end else if (clr && !any_src) begin
            trip_a_q <= 1'b0;
        end
    end

    // independent second line, own flop and own set/clear decision
    always_ff @(posedge clk) begin
        if (rst) trip_b_q <= 1'b0;
        else if (!trip_b_q) trip_b_q <= any_src;
        else if (clr && !any_src) trip_b_q <= 1'b0;
    end

    assign trip_a = trip_a_q;
    assign trip_b = trip_b_q;
    assign first  = first_q;

    // R10: redundant lines agree
    a_r10_lines_agree: assert property (@(posedge clk) disable iff (rst)
        trip_a_q == trip_b_q);

    // R7: latched until a clear request
    a_r7_latched: assert property (@(posedge clk) disable iff (rst)
        (trip_a_q && !clr) |=> trip_a_q);

    // R8: clear refused while a source is active
    a_r8_clear_blocked: assert property (@(posedge clk) disable iff (rst)
        (trip_a_q && any_src) |=> trip_a_q);

    // R9: first-fault code is frozen while tripped
    a_r9_first_frozen: assert property (@(posedge clk) disable iff (rst)
        trip_a_q |=> $stable(first_q));

endmodule

// File: rtl/rf_trip_interlock.sv
module rf_trip_interlock
    import itl_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [DATA_W-1:0]      cfg_wdata,
    input  logic                   rf_gate,
    input  logic [RF_CH*LVL_W-1:0] rf_level,
    input  logic [ARC_CH-1:0]      arc_in,
    input  logic [CMP_CH-1:0]      cmp_in,
    input  logic [SW_CH-1:0]       sw_in,
    input  logic                   vac_ok,
    input  logic                   trip_clr,
    output logic                   trip_a,
    output logic                   trip_b,
    output logic [SRC_W-1:0]       first_src
);

    logic [RF_CH*LVL_W-1:0]  thr_flat;
    logic [RF_CH*TLIM_W-1:0] tlim_flat;
    mask_t                   mask;
    logic [RF_CH-1:0]        ch_fault;
    logic [NSRC-1:0]         src;

    itl_cfg_regs u_cfg (
        .clk       (clk),
        .rst       (rst),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .thr_flat  (thr_flat),
        .tlim_flat (tlim_flat),
        .mask      (mask)
    );

    for (genvar c = 0; c < RF_CH; c++) begin : g_ch
        itl_rf_timer u_tmr (
            .clk   (clk),
            .rst   (rst),
            .gate  (rf_gate),
            .level (rf_level[c*LVL_W +: LVL_W]),
            .thr   (thr_flat[c*LVL_W +: LVL_W]),
            .tlim  (tlim_flat[c*TLIM_W +: TLIM_W]),
            .fault (ch_fault[c])
        );
    end

    assign src[S_VAC]               = !vac_ok;
    assign src[S_RF  +: RF_CH]      = ch_fault & mask.rf_en;
    assign src[S_ARC +: ARC_CH]     = arc_in   & mask.arc_en;
    assign src[S_CMP +: CMP_CH]     = cmp_in   & mask.cmp_en;
    assign src[S_SW  +: SW_CH]      = sw_in    & mask.sw_en;

    itl_trip_latch u_latch (
        .clk    (clk),
        .rst    (rst),
        .clr    (trip_clr),
        .src    (src),
        .trip_a (trip_a),
        .trip_b (trip_b),
        .first  (first_src)
    );

    // R6: vacuum loss always trips, masks notwithstanding
    a_r6_vacuum_trips: assert property (@(posedge clk) disable iff (rst)
        !vac_ok |=> (trip_a && trip_b));

    // R5: a masked-off arc input alone cannot start a trip
    a_r5_masked_arc: assert property (@(posedge clk) disable iff (rst)
        (!trip_a && vac_ok && (mask.arc_en == '0) && (mask.rf_en == '0)
         && (mask.cmp_en == '0) && (mask.sw_en == '0)) |=> !trip_a);

endmodule

// File: tb/rf_trip_interlock_tb.sv
module rf_trip_interlock_tb;
    import itl_pkg::*;

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   cfg_we;
    logic [ADDR_W-1:0]      cfg_addr;
    logic [DATA_W-1:0]      cfg_wdata;
    logic                   rf_gate;
    logic [RF_CH*LVL_W-1:0] rf_level;
    logic [ARC_CH-1:0]      arc_in;
    logic [CMP_CH-1:0]      cmp_in;
    logic [SW_CH-1:0]       sw_in;
    logic                   vac_ok;
    logic                   trip_clr;
    logic                   trip_a, trip_b;
    logic [SRC_W-1:0]       first_src;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #2.5 clk = ~clk;

    rf_trip_interlock u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rf_gate(rf_gate), .rf_level(rf_level),
        .arc_in(arc_in), .cmp_in(cmp_in), .sw_in(sw_in), .vac_ok(vac_ok),
        .trip_clr(trip_clr), .trip_a(trip_a), .trip_b(trip_b),
        .first_src(first_src)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_we    = 1'b1;
        cfg_addr  = ADDR_W'(a);
        cfg_wdata = DATA_W'(d);
        tick(1);
        cfg_we = 1'b0;
    endtask

    task automatic clear_trip();
        trip_clr = 1'b1;
        tick(1);
        trip_clr = 1'b0;
        tick(1);
    endtask

    // check both lines and, when tripped, the first-fault code
    task automatic expect_trip(input string tag, input bit exp, input int code);
        check({tag, " trip_a"}, int'(trip_a), int'(exp));
        check({tag, " R10 trip_b"}, int'(trip_b), int'(exp));
        if (exp) check({tag, " R9 code"}, int'(first_src), code);
    endtask

    task automatic set_lvl(input int c, input int v);
        rf_level[c*LVL_W +: LVL_W] = LVL_W'(v);
    endtask

    initial begin
        tick(150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        rf_gate = 1'b0; rf_level = '0; arc_in = '0; cmp_in = '0;
        sw_in = '0; vac_ok = 1'b1; trip_clr = 1'b0;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1: reset state
        check("R1 trip_a reset", int'(trip_a), 0);
        check("R1 trip_b reset", int'(trip_b), 0);
        check("R1 first_src reset", int'(first_src), 0);

        // R1: masks reset disabled
        arc_in = '1; cmp_in = '1; sw_in = '1;
        tick(3);
        expect_trip("R1 masks off", 0, 0);
        arc_in = '0; cmp_in = '0; sw_in = '0;

        // R1: thresholds reset to all-ones, level max never exceeds
        wr(A_RF_EN, 8'hFF);
        rf_gate = 1'b1;
        for (int c = 0; c < RF_CH; c++) set_lvl(c, 12'hFFF);
        tick(5);
        expect_trip("R1 thr all-ones", 0, 0);
        for (int c = 0; c < RF_CH; c++) set_lvl(c, 0);

        // R1/R11: time limit reset to 0 -> one high cycle trips
        wr(A_THR + 0, 100);
        set_lvl(0, 101);
        tick(1);
        set_lvl(0, 0);
        tick(1);
        expect_trip("R1 tlim zero", 1, S_RF + 0);
        clear_trip();
        expect_trip("R7 cleared", 0, 0);

        // R2/R11: per-channel limit sweep
        for (int c = 0; c < RF_CH; c++) begin
            for (int ti = 0; ti < 3; ti++) begin
                int t;
                t = (ti == 0) ? 0 : (ti == 1) ? 1 : 3;
                wr(A_THR + c, 100);
                wr(A_TLIM + c, t);
                for (int k = 0; k <= t + 2; k++) begin
                    set_lvl(c, 101);
                    tick(k);
                    set_lvl(c, 0);
                    tick(2);
                    expect_trip($sformatf("R2 ch%0d T%0d k%0d", c, t, k),
                                k >= t + 1, S_RF + c);
                    if (trip_a) begin
                        clear_trip();
                        check("R7 clear after rf", int'(trip_a), 0);
                    end
                end
            end
        end

        // R3: level equal to threshold does not count
        wr(A_THR + 2, 100);
        wr(A_TLIM + 2, 3);
        set_lvl(2, 100);
        tick(10);
        set_lvl(2, 0);
        tick(2);
        expect_trip("R3 equal level", 0, 0);

        // R3: one at-threshold cycle restarts the count
        set_lvl(2, 101); tick(3);
        set_lvl(2, 100); tick(1);
        set_lvl(2, 101); tick(3);
        set_lvl(2, 0); tick(2);
        expect_trip("R3 level dip", 0, 0);

        // R3: one gate-low cycle restarts the count
        set_lvl(2, 101); tick(3);
        rf_gate = 1'b0; tick(1);
        rf_gate = 1'b1; tick(3);
        set_lvl(2, 0); tick(2);
        expect_trip("R3 gate dip", 0, 0);

        // R2: uninterrupted 4 cycles does trip at T=3
        set_lvl(2, 101); tick(4);
        set_lvl(2, 0); tick(2);
        expect_trip("R2 ch2 run", 1, S_RF + 2);
        clear_trip();

        // R4: gate low, level high for long
        rf_gate = 1'b0;
        for (int c = 0; c < RF_CH; c++) set_lvl(c, 12'hFFF);
        tick(20);
        expect_trip("R4 gate low", 0, 0);
        for (int c = 0; c < RF_CH; c++) set_lvl(c, 0);
        rf_gate = 1'b1;

        // R5/R7: arc sweep
        for (int i = 0; i < ARC_CH; i++) begin
            wr(A_ARC_EN, 0);
            arc_in[i] = 1'b1; tick(2); arc_in[i] = 1'b0; tick(1);
            expect_trip($sformatf("R5 arc%0d masked", i), 0, 0);
            wr(A_ARC_EN, int'(~(14'd1 << i)) & 16'h3FFF);
            arc_in[i] = 1'b1; tick(2); arc_in[i] = 1'b0; tick(1);
            expect_trip($sformatf("R5 arc%0d others", i), 0, 0);
            wr(A_ARC_EN, 1 << i);
            arc_in[i] = 1'b1; tick(1); arc_in[i] = 1'b0; tick(1);
            expect_trip($sformatf("R5 R7 arc%0d", i), 1, S_ARC + i);
            clear_trip();
            check("R7 clear arc", int'(trip_a), 0);
        end
        wr(A_ARC_EN, 0);

        // R5: computed and software inputs
        for (int j = 0; j < CMP_CH; j++) begin
            wr(A_AUX_EN, 0);
            cmp_in[j] = 1'b1; tick(2); cmp_in[j] = 1'b0; tick(1);
            expect_trip($sformatf("R5 cmp%0d masked", j), 0, 0);
            wr(A_AUX_EN, 1 << j);
            cmp_in[j] = 1'b1; tick(1); cmp_in[j] = 1'b0; tick(1);
            expect_trip($sformatf("R5 cmp%0d", j), 1, S_CMP + j);
            clear_trip();
        end
        for (int j = 0; j < SW_CH; j++) begin
            wr(A_AUX_EN, 0);
            sw_in[j] = 1'b1; tick(2); sw_in[j] = 1'b0; tick(1);
            expect_trip($sformatf("R5 sw%0d masked", j), 0, 0);
            wr(A_AUX_EN, 1 << (CMP_CH + j));
            sw_in[j] = 1'b1; tick(1); sw_in[j] = 1'b0; tick(1);
            expect_trip($sformatf("R5 sw%0d", j), 1, S_SW + j);
            clear_trip();
        end

        // R6: vacuum trips with all masks off and gate low
        wr(A_AUX_EN, 0); wr(A_RF_EN, 0); rf_gate = 1'b0;
        vac_ok = 1'b0; tick(1); vac_ok = 1'b1; tick(1);
        expect_trip("R6 vacuum", 1, S_VAC);
        clear_trip();
        expect_trip("R6 vacuum cleared", 0, 0);

        // R8: clear refused while vacuum held low
        vac_ok = 1'b0; tick(2);
        clear_trip();
        expect_trip("R8 vacuum held", 1, S_VAC);
        vac_ok = 1'b1; tick(1);
        clear_trip();
        expect_trip("R8 vacuum released", 0, 0);

        // R8: clear refused while enabled arc held
        wr(A_ARC_EN, 16'h3FFF);
        arc_in[5] = 1'b1; tick(2);
        clear_trip();
        expect_trip("R8 arc held", 1, S_ARC + 5);
        arc_in[5] = 1'b0; tick(1);
        clear_trip();
        expect_trip("R8 arc released", 0, 0);

        // R8: disabled active source does not block clear
        wr(A_ARC_EN, 0);
        wr(A_AUX_EN, 1 << CMP_CH);
        arc_in = '1;
        sw_in[0] = 1'b1; tick(1); sw_in[0] = 1'b0; tick(1);
        expect_trip("R8 sw trip", 1, S_SW);
        clear_trip();
        expect_trip("R8 disabled source no block", 0, 0);
        arc_in = '0;

        // R9: simultaneous arc3 and sw1 -> arc3 wins
        wr(A_ARC_EN, 16'h3FFF);
        wr(A_AUX_EN, 16'hF);
        arc_in[3] = 1'b1; sw_in[1] = 1'b1; tick(1);
        arc_in[3] = 1'b0; sw_in[1] = 1'b0; tick(1);
        expect_trip("R9 arc3 vs sw1", 1, S_ARC + 3);
        // R9: later lower-code fault does not change code
        arc_in[0] = 1'b1; tick(1); arc_in[0] = 1'b0; tick(1);
        expect_trip("R9 code frozen", 1, S_ARC + 3);
        clear_trip();

        // R9: rf ch7 vs arc0 on same clock -> rf wins
        rf_gate = 1'b1;
        wr(A_RF_EN, 8'hFF);
        wr(A_THR + 7, 100); wr(A_TLIM + 7, 0);
        set_lvl(7, 101); arc_in[0] = 1'b1; tick(1);
        set_lvl(7, 0); arc_in[0] = 1'b0; tick(1);
        expect_trip("R9 ch7 vs arc0", 1, S_RF + 7);
        clear_trip();

        // R9: vacuum vs ch0 -> vacuum wins
        wr(A_THR + 0, 100); wr(A_TLIM + 0, 0);
        set_lvl(0, 101); vac_ok = 1'b0; tick(1);
        set_lvl(0, 0); vac_ok = 1'b1; tick(1);
        expect_trip("R9 vac vs ch0", 1, S_VAC);
        clear_trip();
        expect_trip("R9 final clear", 0, 0);

        // R11: a write to an unmapped address changes nothing
        wr(31, 16'hFFFF);
        set_lvl(1, 12'hFFF); tick(3); set_lvl(1, 0); tick(1);
        expect_trip("R11 unmapped write", 0, 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule